// File: doc/BRIEF.md
# Seconds Timer Interrupt Controller

This block is a fixed-function timekeeping interrupt source. An input tick of roughly 15.6 kHz is divided by a hardwired prescaler into a one-cycle seconds enable. A 16-bit seconds down-counter steps once per enable. When a decrement brings it to zero, a sticky terminal flag is raised. The flag stays up until software writes a new count. While it is up, the counter keeps running through 0xFFFF, so software can fold the overshoot into its next reload.

The flag is gated by a software mask input. The masked result is combined with an unmaskable, active-low external request to drive one active-low CPU interrupt line. A small byte-wide register interface has two addresses. Address 0 is the count port. Address 1 is the control port, and a write to it takes a snapshot of the count for reading. A typical use loads 43200 (one half-day) and lets the flag fire at the half-day boundary. Software then flips its own AM/PM state and reloads.

Top module: `sec_timer_irq`

## Requirements
- R1: After synchronous reset the seconds count reads 0x0000, `term_o` is 0, and `irq_n_o` is 1 while `ext_irq_n_i` is 1.
- R2: The seconds count decrements exactly once for every `PRESCALE_DIV` input ticks (default 15611). Fewer ticks leave it unchanged.
- R3: A count is loaded by two writes to address 0, low byte first and then high byte. The full value replaces the count when the high byte is written, and the next seconds enable decrements from that value.
- R4: `term_o` becomes 1 in the same cycle that a decrement changes the count from 1 to 0. Loading a count of 0 does not raise it, and that count then wraps to 0xFFFF.
- R5: Once `term_o` is 1 it stays 1 while the count wraps to 0xFFFF and keeps decrementing.
- R6: Writing the high byte of a reload clears `term_o`, even when the value written equals the current count. A low-byte write on its own leaves `term_o` unchanged.
- R7: A write to address 1 snapshots the count. The next two reads of address 0 return the snapshot's low byte and then its high byte, unaffected by decrements in between. After the high byte is read, reads follow the live count again, in the same low-then-high order.
- R8: The internal request is active only when `term_o` and `mask_i` are both 1. With `mask_i` at 0, a set flag does not pull `irq_n_o` low.
- R9: When `ext_irq_n_i` is 0, `irq_n_o` is 0 whatever the mask and flag are.
- R10: `irq_n_o` is 1 exactly when `ext_irq_n_i` is 1 and the masked internal request is inactive. This holds for all eight combinations of external input, mask and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per input tick of the time base |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; advances the read byte order |
| addr_i | input | 1 | 0: count port, 1: control (snapshot) port |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte for the current address (0 at address 1) |
| mask_i | input | 1 | 1 lets the terminal flag request an interrupt |
| ext_irq_n_i | input | 1 | Unmaskable external request, active low |
| term_o | output | 1 | Sticky terminal flag |
| irq_n_o | output | 1 | CPU interrupt, active low |

## Verification
The bench runs with a prescaler of 4 so that whole seconds are cheap. It targets the flag's edge cases:
- A load of zero must not fire. A design that compares the count against zero, instead of detecting the decrement from 1 to 0, raises a spurious interrupt there.
- The flag must survive the wrap to 0xFFFF and must survive a lone low-byte write. A design that clears it on the first byte, or when the count leaves zero, drops the interrupt early.
- A reload with the same value must still clear the flag. A design that only clears on a changed value holds the interrupt forever.
- A snapshot must stay frozen across a decrement, which catches a latch that tracks the live count.
- A sweep over all eight combinations of external input, mask and flag catches any inverted polarity or a mask that also gates the external request.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CNT_BYTES = 2;
    localparam int unsigned CNT_W     = BYTE_W * CNT_BYTES;

    typedef logic [CNT_W-1:0]  count_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CTRL  = 1'b1
    } reg_sel_e;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } byte_half_e;

    typedef struct packed {
        count_t value;
        logic   term;
    } countdown_t;

    typedef struct packed {
        count_t     value;
        logic       held;
        byte_half_e half;
    } snapshot_t;

    function automatic byte_t pick_byte(input count_t v, input byte_half_e h);
        return (h == HALF_HI) ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
    endfunction

    function automatic byte_half_e next_half(input byte_half_e h);
        return (h == HALF_LO) ? HALF_HI : HALF_LO;
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned PRESCALE_DIV = 15611
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    output logic sec_stb_o
);
    localparam int unsigned PRE_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             wrap;

    assign wrap = tick_i && (pre_q == PRE_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pre_q     <= '0;
            sec_stb_o <= 1'b0;
        end else begin
            sec_stb_o <= wrap;
            if (tick_i) begin
                pre_q <= wrap ? '0 : pre_q + 1'b1;
            end
        end
    end

    // R2: the divider index never leaves its range
    p_pre_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        pre_q <= PRE_LAST);

    // R2: a seconds enable only follows a tick
    p_stb_after_tick_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        sec_stb_o |-> $past(tick_i));

    generate
        if (PRESCALE_DIV > 1) begin : g_multi
            // R2: consecutive enables cannot occur with a divider above one
            p_stb_single_r2: assert property (@(posedge clk_i) disable iff (rst_i)
                sec_stb_o |=> !sec_stb_o);
        end
    endgenerate

endmodule

// File: rtl/sec_countdown.sv
module sec_countdown
    import sec_timer_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     sec_stb_i,
    input  logic     wr_en_i,
    input  logic     rd_en_i,
    input  reg_sel_e sel_i,
    input  byte_t    wdata_i,
    output byte_t    rdata_o,
    output logic     term_o
);
    countdown_t cd_q;
    snapshot_t  snap_q;
    byte_half_e wr_half_q;
    byte_t      lo_hold_q;

    logic count_wr, ctrl_wr, count_rd, hi_load;
    count_t src_value;

    assign count_wr = wr_en_i && (sel_i == SEL_COUNT);
    assign ctrl_wr  = wr_en_i && (sel_i == SEL_CTRL);
    assign count_rd = rd_en_i && (sel_i == SEL_COUNT);
    assign hi_load  = count_wr && (wr_half_q == HALF_HI);

    // write side: low byte parks in a holding register, high byte commits
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_half_q <= HALF_LO;
            lo_hold_q <= '0;
        end else if (count_wr) begin
            wr_half_q <= next_half(wr_half_q);
            if (wr_half_q == HALF_LO) begin
                lo_hold_q <= wdata_i;
            end
        end
    end

    // countdown and sticky terminal flag
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cd_q <= '{value: '0, term: 1'b0};
        end else if (hi_load) begin
            cd_q.value <= {wdata_i, lo_hold_q};
            cd_q.term  <= 1'b0;
        end else if (sec_stb_i) begin
            cd_q.value <= cd_q.value - 1'b1;
            if (cd_q.value == count_t'(1)) begin
                cd_q.term <= 1'b1;
            end
        end
    end

    // read side: optional snapshot, bytes returned low then high
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            snap_q <= '{value: '0, held: 1'b0, half: HALF_LO};
        end else if (ctrl_wr) begin
            snap_q.value <= cd_q.value;
            snap_q.held  <= 1'b1;
            snap_q.half  <= HALF_LO;
        end else if (count_rd) begin
            snap_q.half <= next_half(snap_q.half);
            if (snap_q.half == HALF_HI) begin
                snap_q.held <= 1'b0;
            end
        end
    end

    assign src_value = snap_q.held ? snap_q.value : cd_q.value;

    always_comb begin
        rdata_o = '0;
        if (sel_i == SEL_COUNT) begin
            rdata_o = pick_byte(src_value, snap_q.half);
        end
    end

    assign term_o = cd_q.term;

    // R5: the flag holds until a high-byte write
    p_term_sticky_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        cd_q.term && !hi_load |=> cd_q.term);

    // R6: a high-byte write always leaves the flag clear
    p_term_clear_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        hi_load |=> !cd_q.term);

    // R4: the flag rises only together with a zero count
    p_term_rise_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cd_q.term) |-> (cd_q.value == '0) && $past(sec_stb_i));

    // R2: each enable without a load takes exactly one off the count
    p_step_one_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        sec_stb_i && !hi_load |=> cd_q.value == $past(cd_q.value) - count_t'(1));

    // R7: a held snapshot does not move while reads are pending
    p_snap_frozen_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        snap_q.held && !ctrl_wr |=> $stable(snap_q.value));

endmodule

// File: rtl/irq_combine.sv
module irq_combine (
    input  logic clk_i,
    input  logic rst_i,
    input  logic term_i,
    input  logic mask_i,
    input  logic ext_irq_n_i,
    output logic irq_n_o
);
    logic internal_req;
    logic external_req;

    assign internal_req = term_i & mask_i;
    assign external_req = ~ext_irq_n_i;
    assign irq_n_o      = ~(internal_req | external_req);

    // R9: external request cannot be masked
    p_ext_wins_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !ext_irq_n_i |-> !irq_n_o);

    // R8: a cleared mask silences the flag
    p_mask_blocks_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !mask_i && ext_irq_n_i |-> irq_n_o);

    // R10: no interrupt without a cause
    p_idle_high_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        ext_irq_n_i && !term_i |-> irq_n_o);

endmodule

// File: rtl/sec_timer_irq.sv
module sec_timer_irq
    import sec_timer_pkg::*;
#(
    parameter int unsigned PRESCALE_DIV = 15611
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic       addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic       mask_i,
    input  logic       ext_irq_n_i,
    output logic       term_o,
    output logic       irq_n_o
);
    logic     sec_stb;
    logic     term;
    reg_sel_e sel;

    assign sel = reg_sel_e'(addr_i);

    tick_prescaler #(.PRESCALE_DIV(PRESCALE_DIV)) u_pre (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick_i),
        .sec_stb_o (sec_stb)
    );

    sec_countdown u_cd (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sec_stb_i (sec_stb),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .sel_i     (sel),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .term_o    (term)
    );

    irq_combine u_irq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .term_i      (term),
        .mask_i      (mask_i),
        .ext_irq_n_i (ext_irq_n_i),
        .irq_n_o     (irq_n_o)
    );

    assign term_o = term;

    // R1: reset leaves the flag low
    p_reset_clear_r1: assert property (@(posedge clk_i)
        $past(rst_i) |-> !term_o);

endmodule

// File: tb/tb_sec_timer_irq.sv
module tb_sec_timer_irq;
    localparam int unsigned DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       mask = 1'b0;
    logic       ext_n = 1'b1;
    logic       term;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    sec_timer_irq #(.PRESCALE_DIV(DIV)) dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .tick_i      (tick),
        .wr_en_i     (wr_en),
        .rd_en_i     (rd_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .mask_i      (mask),
        .ext_irq_n_i (ext_n),
        .term_o      (term),
        .irq_n_o     (irq_n)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] d);
        @(negedge clk);
        addr = 1'b0;
        #1 d = rdata;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(1'b0, v[7:0]);
        wr(1'b0, v[15:8]);
    endtask

    task automatic read_count(output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(1'b1, 8'h00);
        rd_byte(lo);
        rd_byte(hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk);
        check("R1 term", term, 0);
        check("R1 irq_n", irq_n, 1);
        read_count(v);
        check("R1 count", v, 16'h0000);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        load(16'd5);
        ticks(DIV - 1);
        read_count(v);
        check("R2 partial second", v, 5);
        ticks(1);
        read_count(v);
        check("R2 one second", v, 4);
        ticks(DIV);
        read_count(v);
        check("R2 next second", v, 3);
    endtask

    task automatic t_load_order();
        logic [15:0] v;
        load(16'h1234);
        read_count(v);
        check("R3 load value", v, 16'h1234);
        ticks(DIV);
        read_count(v);
        check("R3 first decrement", v, 16'h1233);
    endtask

    task automatic t_terminal();
        logic [15:0] v;
        load(16'd2);
        ticks(DIV);
        check("R4 not yet", term, 0);
        ticks(DIV);
        check("R4 reached zero", term, 1);
        read_count(v);
        check("R4 count zero", v, 0);
        ticks(DIV);
        check("R5 wrap sticky", term, 1);
        read_count(v);
        check("R5 wrap value", v, 16'hFFFF);
        ticks(DIV);
        check("R5 still sticky", term, 1);
        read_count(v);
        check("R5 keeps counting", v, 16'hFFFE);
    endtask

    task automatic t_load_zero();
        logic [15:0] v;
        load(16'd0);
        check("R4 zero load no flag", term, 0);
        ticks(DIV);
        check("R4 zero load wrap no flag", term, 0);
        read_count(v);
        check("R4 zero load wraps", v, 16'hFFFF);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        load(16'd1);
        ticks(DIV);
        check("R6 flag set", term, 1);
        wr(1'b0, 8'hFF);
        check("R6 low byte keeps flag", term, 1);
        wr(1'b0, 8'hFF);
        check("R6 high byte clears", term, 0);
        load(16'd1);
        ticks(DIV);
        check("R6 set again", term, 1);
        read_count(v);
        load(v);
        check("R6 same value clears", term, 0);
    endtask

    task automatic t_latch();
        logic [7:0] lo, hi;
        load(16'h0102);
        wr(1'b1, 8'h00);
        ticks(DIV);
        rd_byte(lo);
        rd_byte(hi);
        check("R7 snapshot frozen", {hi, lo}, 16'h0102);
        rd_byte(lo);
        rd_byte(hi);
        check("R7 live after snapshot", {hi, lo}, 16'h0101);
    endtask

    task automatic set_term(input logic t);
        load(16'd1);
        if (t) ticks(DIV);
    endtask

    task automatic t_irq_table();
        for (int c = 0; c < 8; c++) begin
            logic e, m, t;
            int exp_irq;
            e = c[2]; m = c[1]; t = c[0];
            set_term(t);
            @(negedge clk);
            ext_n = e; mask = m;
            #1;
            exp_irq = (e && !(t && m)) ? 1 : 0;
            if (!e) check("R9 external", irq_n, exp_irq);
            else if (t && !m) check("R8 masked", irq_n, exp_irq);
            else check("R10 table", irq_n, exp_irq);
            check("R10 flag", term, t);
        end
        ext_n = 1'b1; mask = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_prescale();
        t_load_order();
        t_terminal();
        t_load_zero();
        t_clear();
        t_latch();
        t_irq_table();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule